// File: doc/BRIEF.md
# Shift and Rotate Unit with Condition Flags

This unit moves the bits of a byte, word or long operand left or right by a programmable distance and reports the five condition flags extend (X), negative (N), zero (Z), overflow (V) and carry (C). It supports eight variants: arithmetic, logical, plain rotate and rotate through the extend bit, each in both directions. Each variant has its own rules for V, for X and for a zero distance.

The datapath handles one bit position per clock cycle. A caller presents the operand, the size, the variant, the distance and the incoming X flag, then pulses `start`. The unit raises `busy` while it works. When it finishes it pulses `done` for one cycle, and the result and flags stay steady until the next accepted start. The distance is either a three-bit immediate field or a six-bit register value. Bits of the operand above the selected size pass through unchanged.

Top module: `shift_rotate_unit`

## Requirements
- R1: `op` selects the variant: 0 ASR, 1 ASL, 2 LSR, 3 LSL, 4 ROXR, 5 ROXL, 6 ROR, 7 ROL. Bit 0 of `op` set means the bits move toward the most significant bit. The result equals the operand moved by the distance within the selected size. Left shifts fill with 0. LSR fills with 0. ASR replicates the sign bit. Rotates wrap around within the size.
- R2: `size` 0 selects a byte (bits 7:0), 1 a word (bits 15:0), and 2 or 3 a long (bits 31:0). Result bits above the selected size equal the operand bits.
- R3: With `count_imm` high the distance is `count[2:0]`, and the value 0 means 8. With `count_imm` low the distance is the full six-bit `count`, from 0 to 63.
- R4: For LSL and LSR, V is 0, and C and X both receive the last bit shifted out. With a distance of 0, C is 0 and X equals `x_in`.
- R5: For ROL and ROR, X equals `x_in`, V is 0, and C receives the last bit rotated out. With a distance of 0, C is 0.
- R6: For ROXL and ROXR, X takes part in the rotation as a bit above the most significant position. X and C both receive the last bit rotated out. With a distance of 0, C equals `x_in` and X equals `x_in`.
- R7: For ASL, V is 1 exactly when the sign bit of the selected size changes value at any step of the shift. For ASR, V is 0. In both, C and X receive the last bit shifted out. With a distance of 0, C is 0 and X equals `x_in`.
- R8: N is the most significant bit of the result at the selected size. Z is 1 exactly when all result bits within the selected size are 0.
- R9: A `start` accepted while idle with distance n produces a one-cycle `done` pulse n+1 cycles later. `busy` is high from the cycle after acceptance until `done`. A `start` raised while `busy` is ignored.
- R10: After reset, `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a new operation when idle |
| op | input | 3 | Variant select |
| size | input | 2 | Operand size select |
| count_imm | input | 1 | Distance comes from the immediate field |
| count | input | 6 | Distance value |
| operand | input | 32 | Data to shift or rotate |
| x_in | input | 1 | Incoming extend flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Shifted or rotated data |
| flag_x | output | 1 | Extend flag out |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
The unit has no parameters, so the bench builds its single fixed 32-bit configuration. Because the unit spends one cycle per bit, the bench can afford a near-complete sweep. It covers all eight variants, all three sizes, every immediate code, and register distances that straddle each size boundary and the modulo-64 limit. Each run uses six bit patterns and alternates the incoming X. Expected values come from closed-form 64-bit arithmetic, and the bench also checks the latency and that a second start is ignored while the unit is busy.

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  op,
  input  logic [1:0]  size,
  input  logic        count_imm,
  input  logic [5:0]  count,
  input  logic [31:0] operand,
  input  logic        x_in,
  output logic        busy,
  output logic        done,
  output logic [31:0] result,
  output logic        flag_x,
  output logic        flag_n,
  output logic        flag_z,
  output logic        flag_v,
  output logic        flag_c
);

  localparam logic [1:0] K_ARITH = 2'd0;
  localparam logic [1:0] K_LOGIC = 2'd1;
  localparam logic [1:0] K_ROX   = 2'd2;
  localparam logic [1:0] K_ROT   = 2'd3;
  localparam logic [2:0] OP_ASL  = 3'd1;

  logic [31:0] acc;
  logic [5:0]  rem;
  logic [2:0]  op_q;
  logic [1:0]  sz_q;
  logic        x_q, c_q, v_q;

  logic [31:0] msk, topbit, nxt, acc_n;
  logic        msb, below_msb, out_bit, fill_lo, fill_hi, left;
  logic [1:0]  kind;

  assign left = op_q[0];
  assign kind = op_q[2:1];

  always_comb begin
    case (sz_q)
      2'd0:    begin msk = 32'h0000_00FF; topbit = 32'h0000_0080; msb = acc[7];  below_msb = acc[6];  end
      2'd1:    begin msk = 32'h0000_FFFF; topbit = 32'h0000_8000; msb = acc[15]; below_msb = acc[14]; end
      default: begin msk = 32'hFFFF_FFFF; topbit = 32'h8000_0000; msb = acc[31]; below_msb = acc[30]; end
    endcase
  end

  assign out_bit = left ? msb : acc[0];

  always_comb begin
    case (kind)
      K_ROX:   fill_lo = x_q;
      K_ROT:   fill_lo = msb;
      default: fill_lo = 1'b0;
    endcase
    case (kind)
      K_ARITH: fill_hi = msb;
      K_LOGIC: fill_hi = 1'b0;
      K_ROX:   fill_hi = x_q;
      default: fill_hi = acc[0];
    endcase
  end

  assign nxt   = left ? {acc[30:0], fill_lo}
                      : (({1'b0, acc[31:1]} & ~topbit) | (fill_hi ? topbit : 32'd0));
  assign acc_n = (acc & ~msk) | (nxt & msk);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      rem  <= '0;
      acc  <= '0;
      op_q <= '0;
      sz_q <= 2'd2;
      x_q  <= 1'b0;
      c_q  <= 1'b0;
      v_q  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          acc  <= operand;
          op_q <= op;
          sz_q <= size;
          x_q  <= x_in;
          c_q  <= (op[2:1] == K_ROX) ? x_in : 1'b0;
          v_q  <= 1'b0;
          rem  <= count_imm ? ((count[2:0] == 3'd0) ? 6'd8 : {3'd0, count[2:0]}) : count;
        end
      end else if (rem != 6'd0) begin
        rem <= rem - 6'd1;
        acc <= acc_n;
        c_q <= out_bit;
        if (kind != K_ROT) x_q <= out_bit;
        if (op_q == OP_ASL && msb != below_msb) v_q <= 1'b1;
      end else begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  assign result = acc;
  assign flag_x = x_q;
  assign flag_c = c_q;
  assign flag_v = v_q;
  assign flag_n = msb;
  assign flag_z = (acc & msk) == 32'd0;

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_hold_cfg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(op_q) && $stable(sz_q)));
  p_rem_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rem != 6'd0) |=> (rem == $past(rem) - 6'd1));
  p_rot_keeps_x_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && kind == K_ROT) |=> $stable(x_q));
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && kind != K_ARITH) |-> !flag_v);
  p_asr_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == 3'd0) |-> !flag_v);

endmodule

// File: tb/shift_rotate_unit_test.sv
module shift_rotate_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [1:0]  size = '0;
  logic        count_imm = 1'b0;
  logic [5:0]  count = '0;
  logic [31:0] operand = '0;
  logic        x_in = 1'b0;
  logic        busy, done, flag_x, flag_n, flag_z, flag_v, flag_c;
  logic [31:0] result;

  int vectors = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  shift_rotate_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .size(size),
    .count_imm(count_imm), .count(count), .operand(operand), .x_in(x_in),
    .busy(busy), .done(done), .result(result), .flag_x(flag_x),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
  );

  function automatic logic [36:0] model(input logic [2:0] o, input logic [1:0] s,
                                        input int n, input logic [31:0] d, input logic xi);
    int w;
    int k;
    longint unsigned m, a, r, t, v, vm, sa;
    logic x, c, ov;
    w  = (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
    m  = (64'd1 << w) - 1;
    a  = {32'd0, d} & m;
    x  = xi; c = 1'b0; ov = 1'b0; r = a;
    case (o)
      3'd0: begin
        sa = a[w-1] ? (a | ~m) : a;
        r = $unsigned($signed(sa) >>> n) & m;
        if (n != 0) begin c = sa[n-1]; x = c; end
      end
      3'd1, 3'd3: begin
        r = (n > w) ? 64'd0 : ((a << n) & m);
        if (n != 0) begin c = (n <= w) ? a[w-n] : 1'b0; x = c; end
        if (o == 3'd1) begin
          if (n >= w) ov = (a != 0);
          else begin
            t = a >> (w - 1 - n);
            ov = (t != 0) && (t != ((64'd1 << (n + 1)) - 1));
          end
        end
      end
      3'd2: begin
        r = a >> n;
        if (n != 0) begin c = (n <= w) ? a[n-1] : 1'b0; x = c; end
      end
      3'd4, 3'd5: begin
        k  = n % (w + 1);
        v  = ({63'd0, xi} << w) | a;
        vm = (64'd1 << (w + 1)) - 1;
        if (o == 3'd5) v = ((v << k) | (v >> (w + 1 - k))) & vm;
        else           v = ((v >> k) | (v << (w + 1 - k))) & vm;
        r = v & m; x = v[w]; c = x;
      end
      default: begin
        k = n % w;
        if (o == 3'd7) r = ((a << k) | (a >> (w - k))) & m;
        else           r = ((a >> k) | (a << (w - k))) & m;
        if (n != 0) c = (o == 3'd7) ? r[0] : r[w-1];
      end
    endcase
    model = {(d & ~m[31:0]) | r[31:0], x, r[w-1], (r == 0), ov, c};
  endfunction

  function automatic string tag(input logic [2:0] o);
    case (o[2:1])
      2'd0: tag = "R1 R7 R8";
      2'd1: tag = "R1 R4 R8";
      2'd2: tag = "R1 R6 R8";
      default: tag = "R1 R5 R8";
    endcase
  endfunction

  task automatic run(input logic [2:0] o, input logic [1:0] s, input logic im,
                     input logic [5:0] cn, input logic [31:0] d, input logic xi,
                     input logic poke);
    int n;
    int waited;
    logic [36:0] exp, got;
    n = im ? ((cn[2:0] == 3'd0) ? 8 : int'(cn[2:0])) : int'(cn);
    exp = model(o, s, n, d, xi);
    @(negedge clk);
    op = o; size = s; count_imm = im; count = cn; operand = d; x_in = xi; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waited = 0;
    while (!done && waited < 80) begin
      if (poke && waited == 1) begin
        operand = ~d; op = ~o; x_in = ~xi; start = 1'b1;   // R9: ignored while busy
      end else start = 1'b0;
      @(negedge clk);
      waited++;
    end
    start = 1'b0;
    vectors++;
    if (waited != n + 1) begin
      fails++;
      $display("FAIL R9 R3 latency op=%0d size=%0d n=%0d: got %0d expected %0d", o, s, n, waited, n + 1);
    end
    got = {result, flag_x, flag_n, flag_z, flag_v, flag_c};
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s R2 op=%0d size=%0d n=%0d d=%h x=%b: got %h/%b expected %h/%b",
               tag(o), o, s, n, d, xi, got[36:5], got[4:0], exp[36:5], exp[4:0]);
    end
  endtask

  initial begin
    #(5.0 * 190000);
    fails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] pats [6];
    int regc [19];
    logic xb;
    pats = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0001, 32'h1234_5678, 32'hC3A5_7E01, 32'h4000_80FF};
    regc = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 15, 16, 17, 31, 32, 33, 62, 63};
    repeat (3) @(negedge clk);
    vectors++;
    if (busy !== 1'b0 || done !== 1'b0) begin
      fails++;
      $display("FAIL R10 reset: got busy=%b done=%b expected 0 0", busy, done);
    end
    rst_n = 1'b1;
    xb = 1'b0;
    for (int o = 0; o < 8; o++)
      for (int s = 0; s < 3; s++)
        for (int p = 0; p < 6; p++) begin
          for (int c = 0; c < 8; c++) begin
            run(3'(o), 2'(s), 1'b1, 6'(c), pats[p], xb, 1'b0);   // R3 immediate codes
            xb = ~xb;
          end
          for (int c = 0; c < 19; c++) begin
            run(3'(o), 2'(s), 1'b0, 6'(regc[c]), pats[p], xb, 1'b0);
            xb = ~xb;
          end
        end
    run(3'd1, 2'd3, 1'b0, 6'd5, 32'h1234_5678, 1'b1, 1'b1);   // R2 size 3, R9 ignored start
    run(3'd5, 2'd0, 1'b0, 6'd12, 32'hAAAA_AA5A, 1'b0, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule